// File: doc/BRIEF.md
# Interrupt Mask and Pending Register Block

This block holds the per-source mask and the pending status for sixty-four interrupt sources behind a simple byte-addressed register port. Software can replace either 32-bit half of the 64-bit mask outright. It can also raise or drop one mask bit, or every mask bit, with a single one-byte command write. Because no read-modify-write is needed, a masking operation can never lose an update made by another agent between a read and a write.

The sixty-four request lines are sampled into a pending register on every clock. The block drives four outputs:

- the pending flags;
- the pending flags that survive the mask;
- a flag that is high while any unmasked source is pending;
- the index of the lowest-numbered unmasked pending source.

That index can also be read back through the register port as an acknowledge value.

The register port is plain control traffic. There is no valid/ready handshake on it and no back-pressure. A write strobe takes effect at the clock edge that samples it. A read strobe loads the read-data register at that edge, and the register holds its value until the next read.

Top module: `imr_ctrl`

## Requirements
- R1: After reset every mask bit is 1, every pending flag is 0, the masked vector is 0, the active flag is low and the vector output is 0.
- R2: A write to offset 0x08 replaces mask bits 63:32 with the write data, leaves bits 31:0 unchanged, and reading 0x08 returns mask bits 63:32.
- R3: A write to offset 0x0C replaces mask bits 31:0 with the write data, leaves bits 63:32 unchanged, and reading 0x0C returns mask bits 31:0.
- R4: A write to offset 0x1C with data bit 6 set makes every mask bit 1, whatever bits 5:0 hold.
- R5: A write to offset 0x1C with data bit 6 clear sets only the mask bit numbered by data bits 5:0 (0 to 63, so 32 to 63 reach the upper half); all other mask bits keep their value.
- R6: A write to offset 0x1D with data bit 6 set makes every mask bit 0.
- R7: A write to offset 0x1D with data bit 6 clear clears only the mask bit numbered by data bits 5:0; all other mask bits keep their value.
- R8: Reads of offsets 0x1C and 0x1D always return 0.
- R9: The pending flags take the value of the request inputs at every clock edge; reading 0x10 returns flags 63:32 and reading 0x14 returns flags 31:0.
- R10: The masked output equals the pending flags AND NOT the mask, and the active flag is high exactly when that vector is nonzero.
- R11: The vector output is the lowest index set in the masked vector (0 when none is set), and reading 0xE0 returns it in bits 5:0 with all other bits 0.
- R12: Read data changes only on a clock edge where the read strobe is high and then holds; reads of unmapped offsets return 0, and writes to unmapped offsets leave the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wr_en | input | 1 | Write strobe |
| bus_wr_data | input | 32 | Write data; command writes use bits 6:0 |
| bus_rd_en | input | 1 | Read strobe |
| bus_rd_data | output | 32 | Registered read data, valid the cycle after the strobe |
| irq_req_i | input | 64 | Raw interrupt request lines |
| irq_pend_o | output | 64 | Pending flags |
| irq_masked_o | output | 64 | Pending flags that are not masked |
| irq_any_o | output | 1 | High while any unmasked source is pending |
| irq_vec_o | output | 6 | Lowest-numbered unmasked pending source |

## Verification
The assertions assume the following about the inputs:

- reset is held low across at least one rising edge at start-up;
- the request lines are synchronous to the clock;
- address and write data are known whenever a strobe is high.

If these did not hold, the index carried by a command would be unknown, and the property that a single bit was set could not be evaluated.

The stimulus changes every input on the falling edge and holds it for a whole cycle. It never issues a read and a write in the same cycle, and it samples outputs only on falling edges. The sweeps cover:

- every set and clear index;
- every single-source vector position;
- mixed mask and request patterns computed arithmetically.

// File: rtl/imr_pkg.sv
package imr_pkg;

  localparam int unsigned BUS_ADDR_W = 8;

  localparam logic [BUS_ADDR_W-1:0] OFS_MASK_HI = 8'h08;
  localparam logic [BUS_ADDR_W-1:0] OFS_MASK_LO = 8'h0C;
  localparam logic [BUS_ADDR_W-1:0] OFS_PEND_HI = 8'h10;
  localparam logic [BUS_ADDR_W-1:0] OFS_PEND_LO = 8'h14;
  localparam logic [BUS_ADDR_W-1:0] OFS_CMD_SET = 8'h1C;
  localparam logic [BUS_ADDR_W-1:0] OFS_CMD_CLR = 8'h1D;
  localparam logic [BUS_ADDR_W-1:0] OFS_VECTOR  = 8'hE0;

  typedef enum logic [2:0] {
    MOP_IDLE,
    MOP_LOAD_HI,
    MOP_LOAD_LO,
    MOP_SET_ONE,
    MOP_SET_ALL,
    MOP_CLR_ONE,
    MOP_CLR_ALL
  } mask_op_e;

endpackage

// File: rtl/imr_cmd_dec.sv
module imr_cmd_dec
  import imr_pkg::*;
#(
  parameter int unsigned IDX_W = 6
) (
  input  logic                  wr_en,
  input  logic [BUS_ADDR_W-1:0] addr,
  input  logic [IDX_W:0]        cmd_byte,
  output mask_op_e              op,
  output logic [IDX_W-1:0]      idx
);

  logic all_flag;

  assign all_flag = cmd_byte[IDX_W];
  assign idx      = cmd_byte[IDX_W-1:0];

  always_comb begin
    op = MOP_IDLE;
    if (wr_en) begin
      unique case (addr)
        OFS_MASK_HI: op = MOP_LOAD_HI;
        OFS_MASK_LO: op = MOP_LOAD_LO;
        OFS_CMD_SET: op = all_flag ? MOP_SET_ALL : MOP_SET_ONE;
        OFS_CMD_CLR: op = all_flag ? MOP_CLR_ALL : MOP_CLR_ONE;
        default:     op = MOP_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/imr_mask_reg.sv
module imr_mask_reg
  import imr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  mask_op_e                 op,
  input  logic [$clog2(2*DATA_W)-1:0] idx,
  input  logic [DATA_W-1:0]        wr_data,
  output logic [2*DATA_W-1:0]      mask_q
);

  localparam int unsigned NUM_SRC = 2 * DATA_W;
  localparam int unsigned IDX_W   = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0] load_hi_v;
  logic [NUM_SRC-1:0] load_lo_v;
  logic [NUM_SRC-1:0] mask_nxt;

  assign load_hi_v = {wr_data, mask_q[DATA_W-1:0]};
  assign load_lo_v = {mask_q[NUM_SRC-1:DATA_W], wr_data};

  for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit
    logic hit;
    assign hit = (idx == IDX_W'(b));
    assign mask_nxt[b] =
      (op == MOP_LOAD_HI)         ? load_hi_v[b] :
      (op == MOP_LOAD_LO)         ? load_lo_v[b] :
      (op == MOP_SET_ALL)         ? 1'b1 :
      (op == MOP_CLR_ALL)         ? 1'b0 :
      (op == MOP_SET_ONE && hit)  ? 1'b1 :
      (op == MOP_CLR_ONE && hit)  ? 1'b0 :
                                    mask_q[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '1;
    else        mask_q <= mask_nxt;
  end

  AST_SET_ONE_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    (op == MOP_SET_ONE) |=> mask_q[$past(idx)]); // R5
  AST_CLR_ONE_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    (op == MOP_CLR_ONE) |=> !mask_q[$past(idx)]); // R7
  AST_SET_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (op == MOP_SET_ALL) |=> (&mask_q)); // R4
  AST_CLR_ALL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (op == MOP_CLR_ALL) |=> (mask_q == '0)); // R6
  AST_HI_LOAD_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (op == MOP_LOAD_HI) |=> (mask_q[DATA_W-1:0] == $past(mask_q[DATA_W-1:0]))); // R2
  AST_LO_LOAD_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (op == MOP_LOAD_LO) |=> (mask_q[NUM_SRC-1:DATA_W] == $past(mask_q[NUM_SRC-1:DATA_W]))); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (op == MOP_IDLE) |=> $stable(mask_q)); // R12

endmodule

// File: rtl/imr_pend_reg.sv
module imr_pend_reg #(
  parameter int unsigned NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic [NUM_SRC-1:0] mask_i,
  output logic [NUM_SRC-1:0] pend_q,
  output logic [NUM_SRC-1:0] masked_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= irq_i;
  end

  assign masked_o = pend_q & ~mask_i;

  AST_PEND_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pend_q == $past(irq_i))); // R9

endmodule

// File: rtl/imr_lowest_find.sv
module imr_lowest_find #(
  parameter int unsigned NUM_SRC = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_SRC-1:0]         vec_i,
  output logic [$clog2(NUM_SRC)-1:0] idx_o,
  output logic                       found_o
);

  localparam int unsigned IDX_W = $clog2(NUM_SRC);

  always_comb begin
    idx_o   = '0;
    found_o = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        idx_o   = IDX_W'(i);
        found_o = 1'b1;
      end
    end
  end

  AST_VEC_IS_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    found_o |-> (vec_i[idx_o] &&
      ((vec_i & ((NUM_SRC'(1) << idx_o) - NUM_SRC'(1))) == '0))); // R11
  AST_VEC_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !found_o |-> (idx_o == '0)); // R11

endmodule

// File: rtl/imr_rd_mux.sv
module imr_rd_mux
  import imr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd_en,
  input  logic [BUS_ADDR_W-1:0]       addr,
  input  logic [2*DATA_W-1:0]         mask_i,
  input  logic [2*DATA_W-1:0]         pend_i,
  input  logic [$clog2(2*DATA_W)-1:0] vec_i,
  output logic [DATA_W-1:0]           rd_q
);

  localparam int unsigned NUM_SRC = 2 * DATA_W;

  logic [DATA_W-1:0] rd_sel;

  always_comb begin
    unique case (addr)
      OFS_MASK_HI: rd_sel = mask_i[NUM_SRC-1:DATA_W];
      OFS_MASK_LO: rd_sel = mask_i[DATA_W-1:0];
      OFS_PEND_HI: rd_sel = pend_i[NUM_SRC-1:DATA_W];
      OFS_PEND_LO: rd_sel = pend_i[DATA_W-1:0];
      OFS_VECTOR:  rd_sel = DATA_W'(vec_i);
      default:     rd_sel = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_sel;
  end

  AST_CMD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr == OFS_CMD_SET || addr == OFS_CMD_CLR)) |=> (rd_q == '0)); // R8
  AST_RD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_q)); // R12

endmodule

// File: rtl/imr_ctrl.sv
module imr_ctrl
  import imr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [BUS_ADDR_W-1:0]           bus_addr,
  input  logic                            bus_wr_en,
  input  logic [DATA_W-1:0]               bus_wr_data,
  input  logic                            bus_rd_en,
  output logic [DATA_W-1:0]               bus_rd_data,
  input  logic [2*DATA_W-1:0]             irq_req_i,
  output logic [2*DATA_W-1:0]             irq_pend_o,
  output logic [2*DATA_W-1:0]             irq_masked_o,
  output logic                            irq_any_o,
  output logic [$clog2(2*DATA_W)-1:0]     irq_vec_o
);

  localparam int unsigned NUM_SRC = 2 * DATA_W;
  localparam int unsigned IDX_W   = $clog2(NUM_SRC);

  mask_op_e           mask_op;
  logic [IDX_W-1:0]   cmd_idx;
  logic [NUM_SRC-1:0] mask_q;

  imr_cmd_dec #(.IDX_W(IDX_W)) dec_i (
    .wr_en    (bus_wr_en),
    .addr     (bus_addr),
    .cmd_byte (bus_wr_data[IDX_W:0]),
    .op       (mask_op),
    .idx      (cmd_idx)
  );

  imr_mask_reg #(.DATA_W(DATA_W)) mask_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (mask_op),
    .idx     (cmd_idx),
    .wr_data (bus_wr_data),
    .mask_q  (mask_q)
  );

  imr_pend_reg #(.NUM_SRC(NUM_SRC)) pend_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_i    (irq_req_i),
    .mask_i   (mask_q),
    .pend_q   (irq_pend_o),
    .masked_o (irq_masked_o)
  );

  imr_lowest_find #(.NUM_SRC(NUM_SRC)) find_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .vec_i   (irq_masked_o),
    .idx_o   (irq_vec_o),
    .found_o (irq_any_o)
  );

  imr_rd_mux #(.DATA_W(DATA_W)) rd_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_en  (bus_rd_en),
    .addr   (bus_addr),
    .mask_i (mask_q),
    .pend_i (irq_pend_o),
    .vec_i  (irq_vec_o),
    .rd_q   (bus_rd_data)
  );

  AST_MASKED_SOURCE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any_o |-> (irq_pend_o[irq_vec_o] && !mask_q[irq_vec_o])); // R10
  AST_MASKED_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_masked_o & mask_q) == '0) && ((irq_masked_o & ~irq_pend_o) == '0)); // R10

endmodule

// File: tb/imr_ctrl_tb_top.sv
module imr_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr_en;
  logic [31:0] bus_wr_data;
  logic        bus_rd_en;
  logic [31:0] bus_rd_data;
  logic [63:0] irq_req_i;
  logic [63:0] irq_pend_o;
  logic [63:0] irq_masked_o;
  logic        irq_any_o;
  logic [5:0]  irq_vec_o;

  int          n_cmp = 0;
  int          n_bad = 0;
  logic [63:0] exp_mask;
  logic [63:0] exp_pend;
  logic [31:0] rdv;

  always #5 clk = ~clk;

  imr_ctrl dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wr_en    (bus_wr_en),
    .bus_wr_data  (bus_wr_data),
    .bus_rd_en    (bus_rd_en),
    .bus_rd_data  (bus_rd_data),
    .irq_req_i    (irq_req_i),
    .irq_pend_o   (irq_pend_o),
    .irq_masked_o (irq_masked_o),
    .irq_any_o    (irq_any_o),
    .irq_vec_o    (irq_vec_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] lowest(input logic [63:0] v);
    logic [63:0] r;
    r = 64'd0;
    for (int i = 63; i >= 0; i--) if (v[i]) r = 64'(i);
    return r;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr_data = d; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd_en = 1'b1;
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rd_data;
  endtask

  task automatic drive_irq(input logic [63:0] v);
    @(negedge clk);
    irq_req_i = v;
    exp_pend = v;
    @(negedge clk);
  endtask

  task automatic check_outs(input string tag);
    logic [63:0] m;
    m = exp_pend & ~exp_mask;
    chk({tag, " masked"}, irq_masked_o, m);
    chk({tag, " any"}, {63'd0, irq_any_o}, {63'd0, (m != 64'd0)});
    chk({tag, " vec"}, {58'd0, irq_vec_o}, lowest(m));
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = 8'h00; bus_wr_en = 1'b0; bus_wr_data = 32'd0;
    bus_rd_en = 1'b0; irq_req_i = 64'd0;
    exp_mask = '1; exp_pend = 64'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 pend", irq_pend_o, 64'd0);
    check_outs("R1");
    rd(8'h08, rdv); chk("R1 mask hi", {32'd0, rdv}, 64'hFFFF_FFFF);
    rd(8'h0C, rdv); chk("R1 mask lo", {32'd0, rdv}, 64'hFFFF_FFFF);

    // R9 pending sampling and readback
    drive_irq('1);
    chk("R9 pend all", irq_pend_o, '1);
    rd(8'h10, rdv); chk("R9 pend hi", {32'd0, rdv}, 64'hFFFF_FFFF);
    drive_irq(64'h0123_4567_89AB_CDEF);
    chk("R9 pend pat", irq_pend_o, 64'h0123_4567_89AB_CDEF);
    rd(8'h10, rdv); chk("R9 pend hi pat", {32'd0, rdv}, 64'h0123_4567);
    rd(8'h14, rdv); chk("R9 pend lo pat", {32'd0, rdv}, 64'h89AB_CDEF);
    check_outs("R10 all masked");
    drive_irq('1);

    // R6 clear all
    wr(8'h1D, 32'h40);
    exp_mask = 64'd0;
    check_outs("R6");

    // R5 cumulative set sweep over all indices
    for (int i = 0; i < 64; i++) begin
      wr(8'h1C, 32'(i));
      exp_mask[i] = 1'b1;
      check_outs("R5/R11 set sweep");
    end

    // R4 set all after clear all, junk index
    wr(8'h1D, 32'h40); exp_mask = 64'd0;
    wr(8'h1C, 32'h47); exp_mask = '1;
    check_outs("R4");

    // R7 clear sweep
    for (int i = 0; i < 64; i++) begin
      wr(8'h1D, 32'(i));
      exp_mask[i] = 1'b0;
      check_outs("R7 clr sweep");
    end

    // R2 upper half load
    wr(8'h1C, 32'h40); exp_mask = '1;
    wr(8'h08, 32'hA5A5_0F0F); exp_mask[63:32] = 32'hA5A5_0F0F;
    rd(8'h08, rdv); chk("R2 hi readback", {32'd0, rdv}, 64'hA5A5_0F0F);
    rd(8'h0C, rdv); chk("R2 lo kept", {32'd0, rdv}, 64'hFFFF_FFFF);
    check_outs("R2");

    // R3 lower half load
    wr(8'h0C, 32'h1234_5678); exp_mask[31:0] = 32'h1234_5678;
    rd(8'h0C, rdv); chk("R3 lo readback", {32'd0, rdv}, 64'h1234_5678);
    rd(8'h08, rdv); chk("R3 hi kept", {32'd0, rdv}, 64'hA5A5_0F0F);
    check_outs("R3");

    // R8 command offsets read as zero
    rd(8'h08, rdv);
    rd(8'h1C, rdv); chk("R8 read 1C", {32'd0, rdv}, 64'd0);
    rd(8'h08, rdv);
    rd(8'h1D, rdv); chk("R8 read 1D", {32'd0, rdv}, 64'd0);

    // R12 unmapped accesses and hold
    wr(8'h20, 32'hFFFF_FFFF); check_outs("R12 unmapped wr 20");
    wr(8'h1E, 32'h0000_0000); check_outs("R12 unmapped wr 1E");
    rd(8'h30, rdv); chk("R12 unmapped rd", {32'd0, rdv}, 64'd0);
    rd(8'h08, rdv);
    repeat (3) @(negedge clk);
    chk("R12 rd hold", {32'd0, bus_rd_data}, 64'hA5A5_0F0F);

    // R10/R11 mixed patterns
    for (int k = 1; k <= 12; k++) begin
      logic [63:0] pv, mv;
      pv = 64'(k) * 64'h9E37_79B9_7F4A_7C15;
      mv = ~(pv ^ (pv >> k)) | (64'd1 << (k * 5));
      wr(8'h08, mv[63:32]); wr(8'h0C, mv[31:0]); exp_mask = mv;
      drive_irq(pv);
      check_outs("R10/R11 pattern");
      rd(8'hE0, rdv); chk("R11 vec read pattern", {32'd0, rdv}, lowest(pv & ~mv));
    end

    // R11 single-position vector sweep
    wr(8'h1D, 32'h40); exp_mask = 64'd0;
    for (int i = 0; i < 64; i++) begin
      drive_irq('1 << i);
      check_outs("R11 vec sweep");
      rd(8'hE0, rdv); chk("R11 vec read", {32'd0, rdv}, 64'(i));
    end
    drive_irq(64'd0);
    check_outs("R10 none pending");
    rd(8'hE0, rdv); chk("R11 vec read none", {32'd0, rdv}, 64'd0);

    summary();
    $finish;
  end

endmodule